// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh duty for an asynchronous DRAM array built from two banks. After reset it waits out a power-up pause, then issues a burst of CAS-before-RAS refresh cycles before it lets normal traffic start. From then on an interval timer raises a refresh request at a fixed rate. The access controller grants the request once its current access has finished. The sequencer then takes the RAS, CAS and WE pins and runs one or more refresh cycles. Every RAS and CAS line is driven together, so both banks refresh at once. The DRAM's internal counter supplies the row, so no row address is produced.

If the controller cannot grant at once, the missed intervals are counted up to a set limit. They are later issued as one burst, with CAS held low while RAS toggles. When the grant comes at the end of a read that still holds CAS low, the controller can flag it as a hidden refresh. The sequencer then keeps CAS low, raises RAS for a precharge and lowers it again, so the read data stays driven. All timing is counted in clock cycles through parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it, every RAS and CAS line is high and `init_done`, `ref_req` and `seq_active` are low.
- R2: After reset no RAS line falls for at least `INIT_WAIT_CYC` cycles. Then exactly `INIT_REFRESHES` refresh cycles run before `init_done` rises, and `ref_req` stays low until then.
- R3: In each refresh cycle CAS is low in the sample before RAS falls and in the sample where it falls. On a normal start RAS falls `CAS_LEAD_CYC` cycles after `seq_active` rises. CAS stays low for as long as RAS is low.
- R4: `we_n` is high in every cycle in which RAS falls for refresh.
- R5: RAS stays low for exactly `RAS_LOW_CYC` cycles per refresh. It stays high for exactly `RAS_HIGH_CYC` cycles between cycles of a burst, and for the same span after the last cycle before `seq_active` drops.
- R6: All pending refreshes run as one burst. CAS stays low through the RAS-high gaps inside the burst.
- R7: After `init_done`, one refresh interval elapses every `REF_INTERVAL_CYC` cycles, so `ref_req` rises on that grid. A grant given while `ref_req` is low has no effect.
- R8: Missed intervals are counted up to `MAX_PENDING`. Intervals beyond that are dropped, and the next burst then holds exactly `MAX_PENDING` cycles. After a burst `ref_req` is low.
- R9: All RAS lines fall together, and all CAS lines are low together, during refresh.
- R10: A grant with `hidden_ok` high starts with CAS low and RAS high. RAS then falls after `RAS_HIGH_CYC` cycles, and the pending count is issued in the same way as a normal burst.
- R11: `ref_req` stays high and the pins stay idle until a grant arrives. The cycle after the grant is sampled, `seq_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Grant from the access controller |
| hidden_ok | input | 1 | With grant: CAS is still low from a read, so do a hidden refresh |
| ref_req | output | 1 | Refresh wanted |
| init_done | output | 1 | Power-up sequence complete; normal access allowed |
| seq_active | output | 1 | Sequencer owns the DRAM control pins |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
The bench builds the block with a 20-cycle power-up pause, a 40-cycle refresh interval, a 1-cycle CAS lead, 3 cycles of RAS low, 2 cycles of RAS high and a queue limit of 3. With these values the power-up burst of eight cycles and many refresh intervals fit in a short run. By delaying the grant across one, two or four intervals, the bench produces bursts of one, two and three cycles and also the saturated queue. It does this for both normal and hidden starts.

// File: rtl/dref_pkg.sv
package dref_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_LEAD,
        ST_ACT,
        ST_PRE
    } seq_state_e;
endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
    parameter int INIT_WAIT_CYC    = 10000,
    parameter int REF_INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic pwrup_done_o,
    output logic tick_o
);
    localparam int CNT_MAX = (INIT_WAIT_CYC > REF_INTERVAL_CYC) ? INIT_WAIT_CYC : REF_INTERVAL_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(INIT_WAIT_CYC - 1);
    localparam logic [CW-1:0] INT_LAST  = CW'(REF_INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pwr;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d            = q;
        pwrup_done_o = 1'b0;
        tick_o       = 1'b0;
        if (!q.pwr) begin
            if (q.cnt == WAIT_LAST) begin
                pwrup_done_o = 1'b1;
                d.pwr        = 1'b1;
                d.cnt        = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (run_i) begin
            if (q.cnt == INT_LAST) begin
                tick_o = 1'b1;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // the power-up pause ends only once per reset
    assert_single_pwrup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup_done_o |=> !pwrup_done_o);
endmodule

// File: rtl/dref_pending_ctr.sv
module dref_pending_ctr #(
    parameter int INIT_REFRESHES = 8,
    parameter int MAX_PENDING    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    input  logic take_i,
    output logic nz_o
);
    localparam int TOP = (INIT_REFRESHES > MAX_PENDING) ? INIT_REFRESHES : MAX_PENDING;
    localparam int PW  = $clog2(TOP + 1);
    localparam logic [PW-1:0] CAP  = PW'(MAX_PENDING);
    localparam logic [PW-1:0] INIT = PW'(INIT_REFRESHES);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pend_t;

    pend_t q, d;
    logic  inc;

    always_comb begin
        d   = q;
        inc = tick_i && ((q.cnt < CAP) || take_i);
        if (load_i) begin
            d.cnt = INIT;
        end else if (inc && !take_i) begin
            d.cnt = q.cnt + 1'b1;
        end else if (take_i && !inc) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    assign nz_o = (q.cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !take_i && !load_i && q.cnt == CAP) |=> (q.cnt == CAP));

    assert_take_has_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> nz_o);
endmodule

// File: rtl/dref_cycle_fsm.sv
module dref_cycle_fsm
    import dref_pkg::*;
#(
    parameter int NUM_RAS      = 4,
    parameter int NUM_CAS      = 4,
    parameter int CAS_LEAD_CYC = 1,
    parameter int RAS_LOW_CYC  = 6,
    parameter int RAS_HIGH_CYC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwrup_done_i,
    input  logic               pend_nz_i,
    input  logic               ref_gnt_i,
    input  logic               hidden_i,
    output logic               take_o,
    output logic               ref_req_o,
    output logic               init_done_o,
    output logic               seq_active_o,
    output logic [NUM_RAS-1:0] ras_n_o,
    output logic [NUM_CAS-1:0] cas_n_o,
    output logic               we_n_o
);
    localparam int PH_MAX = (RAS_LOW_CYC > RAS_HIGH_CYC) ?
                            ((RAS_LOW_CYC > CAS_LEAD_CYC) ? RAS_LOW_CYC : CAS_LEAD_CYC) :
                            ((RAS_HIGH_CYC > CAS_LEAD_CYC) ? RAS_HIGH_CYC : CAS_LEAD_CYC);
    localparam int PHW = $clog2(PH_MAX + 1);
    localparam logic [PHW-1:0] LEAD_LAST = PHW'(CAS_LEAD_CYC - 1);
    localparam logic [PHW-1:0] LOW_LAST  = PHW'(RAS_LOW_CYC - 1);
    localparam logic [PHW-1:0] HIGH_LAST = PHW'(RAS_HIGH_CYC - 1);

    typedef struct packed {
        seq_state_e     state;
        logic [PHW-1:0] phase;
        logic           hold;
        logic           init;
    } fsm_t;

    fsm_t q, d;
    logic ras_drv, cas_drv;

    assign ref_req_o = q.init && (q.state == ST_IDLE) && pend_nz_i;

    always_comb begin
        d      = q;
        take_o = 1'b0;
        unique case (q.state)
            ST_PWRUP: begin
                if (pwrup_done_i) begin
                    d.state = ST_LEAD;
                    d.phase = LEAD_LAST;
                end
            end
            ST_IDLE: begin
                if (ref_req_o && ref_gnt_i) begin
                    if (hidden_i) begin
                        d.state = ST_PRE;
                        d.phase = HIGH_LAST;
                        d.hold  = 1'b1;
                    end else begin
                        d.state = ST_LEAD;
                        d.phase = LEAD_LAST;
                    end
                end
            end
            ST_LEAD: begin
                if (q.phase == '0) begin
                    d.state = ST_ACT;
                    d.phase = LOW_LAST;
                    take_o  = 1'b1;
                end else begin
                    d.phase = q.phase - 1'b1;
                end
            end
            ST_ACT: begin
                if (q.phase == '0) begin
                    d.state = ST_PRE;
                    d.phase = HIGH_LAST;
                    d.hold  = pend_nz_i;
                end else begin
                    d.phase = q.phase - 1'b1;
                end
            end
            ST_PRE: begin
                if (q.phase == '0) begin
                    if (q.hold) begin
                        d.state = ST_ACT;
                        d.phase = LOW_LAST;
                        take_o  = 1'b1;
                    end else begin
                        d.state = ST_IDLE;
                        d.init  = 1'b1;
                    end
                end else begin
                    d.phase = q.phase - 1'b1;
                end
            end
            default: d.state = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_PWRUP;
        end else begin
            q <= d;
        end
    end

    assign ras_drv      = (q.state == ST_ACT);
    assign cas_drv      = (q.state == ST_LEAD) || (q.state == ST_ACT) ||
                          ((q.state == ST_PRE) && q.hold);
    assign seq_active_o = (q.state == ST_LEAD) || (q.state == ST_ACT) || (q.state == ST_PRE);
    assign init_done_o  = q.init;
    assign we_n_o       = 1'b1;

    for (genvar g = 0; g < NUM_RAS; g++) begin : g_ras
        assign ras_n_o[g] = !ras_drv;
    end
    for (genvar g = 0; g < NUM_CAS; g++) begin : g_cas
        assign cas_n_o[g] = !cas_drv;
    end

    assert_cas_before_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o[0]) |-> (!cas_n_o[0] && !$past(cas_n_o[0])));

    assert_cas_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n_o[0] && !ras_n_o[0]) |=> (!cas_n_o[0] || ras_n_o[0]));

    assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_active_o && !ref_req_o && q.state == ST_IDLE) |=> !seq_active_o);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int NUM_RAS          = 4,
    parameter int NUM_CAS          = 4,
    parameter int INIT_WAIT_CYC    = 10000,
    parameter int INIT_REFRESHES   = 8,
    parameter int REF_INTERVAL_CYC = 1562,
    parameter int CAS_LEAD_CYC     = 1,
    parameter int RAS_LOW_CYC      = 6,
    parameter int RAS_HIGH_CYC     = 5,
    parameter int MAX_PENDING      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_gnt,
    input  logic               hidden_ok,
    output logic               ref_req,
    output logic               init_done,
    output logic               seq_active,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n
);
    logic pwrup_done, tick, take, pend_nz;

    dref_interval_timer #(
        .INIT_WAIT_CYC   (INIT_WAIT_CYC),
        .REF_INTERVAL_CYC(REF_INTERVAL_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (init_done),
        .pwrup_done_o(pwrup_done),
        .tick_o      (tick)
    );

    dref_pending_ctr #(
        .INIT_REFRESHES(INIT_REFRESHES),
        .MAX_PENDING   (MAX_PENDING)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(pwrup_done),
        .tick_i(tick),
        .take_i(take),
        .nz_o  (pend_nz)
    );

    dref_cycle_fsm #(
        .NUM_RAS     (NUM_RAS),
        .NUM_CAS     (NUM_CAS),
        .CAS_LEAD_CYC(CAS_LEAD_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .RAS_HIGH_CYC(RAS_HIGH_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwrup_done_i(pwrup_done),
        .pend_nz_i   (pend_nz),
        .ref_gnt_i   (ref_gnt),
        .hidden_i    (hidden_ok),
        .take_o      (take),
        .ref_req_o   (ref_req),
        .init_done_o (init_done),
        .seq_active_o(seq_active),
        .ras_n_o     (ras_n),
        .cas_n_o     (cas_n),
        .we_n_o      (we_n)
    );

    // interval timer only runs once the power-up burst is over
    assert_tick_after_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> init_done);

    assert_no_req_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);
endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
    localparam int NUM_RAS  = 4;
    localparam int NUM_CAS  = 4;
    localparam int INIT_W   = 20;
    localparam int INIT_REF = 8;
    localparam int INTERVAL = 40;
    localparam int LEAD     = 1;
    localparam int LOW      = 3;
    localparam int HIGH     = 2;
    localparam int MAXP     = 3;
    localparam int NV       = 8;

    // {grant delay[23:8], hidden[7], expected burst length[6:0]}
    localparam logic [23:0] VEC [NV] = '{
        {16'd5,   1'b0, 7'd1},
        {16'd45,  1'b0, 7'd2},
        {16'd85,  1'b0, 7'd3},
        {16'd165, 1'b0, 7'd3},
        {16'd5,   1'b1, 7'd1},
        {16'd45,  1'b1, 7'd2},
        {16'd125, 1'b1, 7'd3},
        {16'd5,   1'b0, 7'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0, hidden_ok = 1'b0;
    logic ref_req, init_done, seq_active, we_n;
    logic [NUM_RAS-1:0] ras_n;
    logic [NUM_CAS-1:0] cas_n;

    dram_refresh_seq #(
        .NUM_RAS(NUM_RAS), .NUM_CAS(NUM_CAS), .INIT_WAIT_CYC(INIT_W),
        .INIT_REFRESHES(INIT_REF), .REF_INTERVAL_CYC(INTERVAL),
        .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(LOW), .RAS_HIGH_CYC(HIGH),
        .MAX_PENDING(MAXP)
    ) u_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .hidden_ok(hidden_ok),
        .ref_req(ref_req), .init_done(init_done), .seq_active(seq_active),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, falls = 0, first_fall = -1;
    bit req_early = 1'b0;
    bit prev_ras = 1'b1, prev_cas = 1'b1, prev_act = 1'b0;
    bit in_b = 1'b0, cas_hi = 1'b0, cas_hi_low = 1'b0;
    int low_run = 0, high_run = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // pin monitor: sampled at the falling clock edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_ras = 1'b1; prev_cas = 1'b1; prev_act = 1'b0;
            in_b = 1'b0; low_run = 0; high_run = 0;
        end else begin
            if (!init_done && ref_req) req_early = 1'b1;
            if (prev_ras && !ras_n[0]) begin
                chk(ras_n == '0, "R9 all RAS low together", int'(ras_n), 0);
                chk(cas_n == '0, "R9 all CAS low together", int'(cas_n), 0);
                chk(!prev_cas && !cas_n[0], "R3 CAS low before RAS falls", int'(prev_cas), 0);
                chk(we_n, "R4 WE high at RAS fall", int'(we_n), 1);
                if (in_b) begin
                    chk(high_run == HIGH, "R5 RAS high gap in burst", high_run, HIGH);
                    chk(!cas_hi, "R6 CAS continuous in burst", int'(cas_hi), 0);
                end
                in_b = 1'b0; falls++;
                if (first_fall < 0) first_fall = cyc;
                low_run = 1; cas_hi_low = 1'b0;
            end else if (!ras_n[0]) begin
                low_run++;
                if (cas_n[0]) cas_hi_low = 1'b1;
            end
            if (!prev_ras && ras_n[0]) begin
                chk(low_run == LOW, "R5 RAS low width", low_run, LOW);
                chk(!cas_hi_low, "R3 CAS held while RAS low", int'(cas_hi_low), 0);
                in_b = 1'b1; high_run = 1; cas_hi = cas_n[0];
            end else if (ras_n[0]) begin
                high_run++;
                if (cas_n[0]) cas_hi = 1'b1;
            end
            if (prev_act && !seq_active) begin
                if (in_b) chk(high_run - 1 == HIGH, "R5 final precharge", high_run - 1, HIGH);
                in_b = 1'b0;
            end
            prev_ras = ras_n[0]; prev_cas = cas_n[0]; prev_act = seq_active;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int t_rel, t0, f0, off;
        bit ok;
        repeat (3) step();
        // R1 reset state
        chk(ras_n == '1 && cas_n == '1, "R1 pins idle in reset", int'(ras_n), 15);
        chk(!init_done && !ref_req && !seq_active, "R1 flags low in reset",
            int'({init_done, ref_req, seq_active}), 0);
        rst_n = 1'b1;
        ref_gnt = 1'b1;                 // grant held during init must not matter
        t_rel = cyc;
        step();
        chk(ras_n == '1 && !init_done && !seq_active, "R1 idle after reset", int'(ras_n), 15);
        while (!init_done) step();
        ref_gnt = 1'b0;
        chk(first_fall - t_rel >= INIT_W, "R2 power-up pause", first_fall - t_rel, INIT_W);
        chk(falls == INIT_REF, "R2 power-up refresh count", falls, INIT_REF);
        chk(!req_early, "R2 no request before init_done", int'(req_early), 0);

        t0 = 0;
        for (int i = 0; i < NV; i++) begin
            int d, ex;
            bit hid;
            d = int'(VEC[i][23:8]); hid = VEC[i][7]; ex = int'(VEC[i][6:0]);
            while (!ref_req) step();
            if (i == 0) t0 = cyc;
            else chk(((cyc - t0) % INTERVAL) == 0, "R7 request on interval grid",
                     (cyc - t0) % INTERVAL, 0);
            repeat (d) step();
            chk(ref_req && !seq_active && ras_n == '1, "R11 waits for grant",
                int'({ref_req, seq_active}), 2);
            f0 = falls;
            hidden_ok = hid;
            ref_gnt = 1'b1;
            step();
            ref_gnt = 1'b0;
            hidden_ok = 1'b0;
            chk(seq_active, "R11 active after grant", int'(seq_active), 1);
            chk(!cas_n[0] && ras_n[0], "R10 CAS low RAS high at start",
                int'({cas_n[0], ras_n[0]}), 1);
            off = 0;
            while (ras_n[0]) begin
                step();
                off++;
            end
            if (hid) chk(off == HIGH, "R10 hidden precharge before RAS", off, HIGH);
            else     chk(off == LEAD, "R3 CAS lead on normal start", off, LEAD);
            while (seq_active) step();
            chk(falls - f0 == ex, "R8 R6 burst length", falls - f0, ex);
            chk(!ref_req, "R8 queue drained", int'(ref_req), 0);
        end

        // R7: grant without a request is ignored
        ok = 1'b1;
        ref_gnt = 1'b1;
        hidden_ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            if (seq_active || ras_n != '1 || cas_n != '1) ok = 1'b0;
        end
        ref_gnt = 1'b0;
        hidden_ok = 1'b0;
        chk(ok, "R7 grant without request ignored", int'(ok), 1);

        // R1 again on a reset in mid-run
        rst_n = 1'b0;
        step();
        chk(ras_n == '1 && cas_n == '1 && !init_done && !ref_req && !seq_active,
            "R1 reset mid-run", int'({init_done, ref_req, seq_active}), 0);
        summary();
        $finish;
    end
endmodule